// File: doc/BRIEF.md
# Sampled-Clock Flip-Flop with Per-Bit Set and Clear

This block behaves like a bank of edge-triggered flip-flops that have asynchronous set and clear inputs, but every storage element in it runs on one fast global clock. The emulated clock is an ordinary data input. The block compares its level with the level held one global cycle earlier, and in that way finds the active transition. When it finds one, the output takes the data value that was present at the previous global edge. In every other cycle the output keeps the value it registered on the previous global cycle.

Two vectors override the result bit by bit, combinationally: one forces bits high and one forces bits low. The force-low vector takes priority. The polarity of the emulated clock edge, of the force-high vector and of the force-low vector are each chosen by their own parameter. The output is fed back into the hold register, so a forced value stays in place after its override is released. It stays until the next active emulated clock edge loads new data. This is how a real set/clear flip-flop retains its state.

The block is meant for a design in which all logic must be clocked by a single fast clock. Slower clocks are carried as data signals in such a design, and this block reproduces the behaviour of a set/clear flip-flop in that setting.

Top module: `sff_sampled_ff`

## Requirements
- R1: While `rst_n` is low, all internal registers are cleared, and the stored emulated-clock level is set to the active level, so no edge is seen just after reset. With no override active, the output is all zeros.
- R2: An active edge exists in a global cycle when the emulated clock is at its active level now and was not at the previous global edge. The active level is high for `CLK_EDGE = EDGE_RISE` and low for `EDGE_FALL`. In that cycle, every bit with no override shows the `d_i` value captured at the most recent global clock edge.
- R3: In a global cycle with no active edge, every bit with no override keeps the output value registered at the previous global edge, whatever `d_i` does.
- R4: A bit whose set line is active reads 1, unless its clear line is also active. A set line is active when high if `SET_ACTIVE_HIGH = 1`, and active when low if it is 0.
- R5: A bit whose clear line is active reads 0, even if its set line is active. A clear line is active when high if `CLR_ACTIVE_HIGH = 1`, and active when low if it is 0. This polarity is independent of the set polarity.
- R6: Overrides act on each bit separately. Bits with no active override load or hold normally in the same cycle.
- R7: After an override is released with no active edge, the bit keeps the forced value.
- R8: An active edge that occurs while a bit's override is held does not load data into that bit. After release, the bit keeps its forced value.
- R9: A transition of the emulated clock to its inactive level loads nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gclk | input | 1 | Fast global sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the internal registers |
| eclk_i | input | 1 | Emulated flip-flop clock, sampled as data |
| d_i | input | WIDTH | Data input |
| set_i | input | WIDTH | Per-bit force-high vector, polarity set by `SET_ACTIVE_HIGH` |
| clr_i | input | WIDTH | Per-bit force-low vector, polarity set by `CLR_ACTIVE_HIGH` |
| q_o | output | WIDTH | Flip-flop output |

## Verification
A wrong stored emulated-clock level shows up at the port in the same cycle, as a load that appears where none was due or that is missing. A stale data register shows up as a loaded value one step older than expected, seen at the first active edge. A hold register that does not capture the final output loses forced values: the error appears on `q_o` in the first global cycle after an override is released. The bench drives four instances, which cover both edge polarities and every combination of set and clear polarity, and checks each result in the cycle where it first becomes visible.

// File: rtl/sff_pkg.sv
package sff_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    // Map a raw line to "asserted" given whether it is active high.
    function automatic logic line_active(input logic raw, input logic active_high);
        return active_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/sff_edge_detect.sv
module sff_edge_detect
    import sff_pkg::*;
#(
    parameter edge_sel_e CLK_EDGE = EDGE_RISE
) (
    input  logic gclk,
    input  logic rst_n,
    input  logic eclk_i,
    output logic edge_o
);
    localparam logic ACTIVE_LVL = (CLK_EDGE == EDGE_RISE);

    typedef struct packed {
        logic lvl;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        cur_active;
    logic        prev_active;

    always_comb begin
        st_d        = st_q;
        st_d.lvl    = eclk_i;
        cur_active  = (eclk_i == ACTIVE_LVL);
        prev_active = (st_q.lvl == ACTIVE_LVL);
        edge_o      = cur_active && !prev_active;
    end

    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= ACTIVE_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge gclk) disable iff (!rst_n)
        edge_o |=> !edge_o) else $error("edge held longer than one cycle"); // R2

endmodule

// File: rtl/sff_hold_core.sv
module sff_hold_core #(
    parameter int WIDTH = 8
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] q_fb_i,
    output logic [WIDTH-1:0] base_o
);
    typedef struct packed {
        logic [WIDTH-1:0] d_prev;
        logic [WIDTH-1:0] q_prev;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.d_prev = d_i;
        st_d.q_prev = q_fb_i;
        base_o      = edge_i ? st_q.d_prev : st_q.q_prev;
    end

    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sff_override.sv
module sff_override
    import sff_pkg::*;
#(
    parameter int WIDTH           = 8,
    parameter bit SET_ACTIVE_HIGH = 1'b1,
    parameter bit CLR_ACTIVE_HIGH = 1'b1
) (
    input  logic [WIDTH-1:0] base_i,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] force_hi;
    logic [WIDTH-1:0] force_lo;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            force_hi[b] = line_active(set_i[b], SET_ACTIVE_HIGH);
            force_lo[b] = line_active(clr_i[b], CLR_ACTIVE_HIGH);
            q_o[b]      = (base_i[b] | force_hi[b]) & ~force_lo[b];
        end
    end

endmodule

// File: rtl/sff_sampled_ff.sv
module sff_sampled_ff
    import sff_pkg::*;
#(
    parameter int        WIDTH           = 8,
    parameter edge_sel_e CLK_EDGE        = EDGE_RISE,
    parameter bit        SET_ACTIVE_HIGH = 1'b1,
    parameter bit        CLR_ACTIVE_HIGH = 1'b1
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  logic             eclk_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);
    logic             edge_w;
    logic [WIDTH-1:0] base_w;

    sff_edge_detect #(.CLK_EDGE(CLK_EDGE)) u_edge (
        .gclk   (gclk),
        .rst_n  (rst_n),
        .eclk_i (eclk_i),
        .edge_o (edge_w)
    );

    sff_hold_core #(.WIDTH(WIDTH)) u_core (
        .gclk   (gclk),
        .rst_n  (rst_n),
        .edge_i (edge_w),
        .d_i    (d_i),
        .q_fb_i (q_o),
        .base_o (base_w)
    );

    sff_override #(
        .WIDTH           (WIDTH),
        .SET_ACTIVE_HIGH (SET_ACTIVE_HIGH),
        .CLR_ACTIVE_HIGH (CLR_ACTIVE_HIGH)
    ) u_ovr (
        .base_i (base_w),
        .set_i  (set_i),
        .clr_i  (clr_i),
        .q_o    (q_o)
    );

    // Port-level views used by the checks below.
    logic [WIDTH-1:0] set_act;
    logic [WIDTH-1:0] clr_act;
    logic             clk_act;
    logic             past_ok_q;

    always_comb begin
        set_act = SET_ACTIVE_HIGH ? set_i : ~set_i;
        clr_act = CLR_ACTIVE_HIGH ? clr_i : ~clr_i;
        clk_act = (CLK_EDGE == EDGE_RISE) ? eclk_i : ~eclk_i;
    end

    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge gclk) disable iff (!rst_n)
        (q_o & clr_act) == '0) else $error("cleared bit not low"); // R5

    AST_SET_FORCES: assert property (@(posedge gclk) disable iff (!rst_n)
        ((~q_o) & set_act & ~clr_act) == '0) else $error("set bit not high"); // R4

    AST_LOAD_ON_EDGE: assert property (@(posedge gclk) disable iff (!rst_n)
        (past_ok_q && clk_act && !$past(clk_act) && set_act == '0 && clr_act == '0)
        |-> (q_o == $past(d_i))) else $error("edge did not load data"); // R2

    AST_HOLD_NO_EDGE: assert property (@(posedge gclk) disable iff (!rst_n)
        (past_ok_q && !(clk_act && !$past(clk_act)) && set_act == '0 && clr_act == '0)
        |-> (q_o == $past(q_o))) else $error("output moved without edge"); // R3

endmodule

// File: tb/sff_sampled_ff_tb.sv
module sff_sampled_ff_tb;
    import sff_pkg::*;

    localparam int W = 8;
    localparam int N = 4;

    logic gclk = 1'b0;
    logic rst_n = 1'b0;
    always #4 gclk = ~gclk;   // 125 MHz

    // Logical stimulus: 1 means "active level" / "asserted".
    logic         l_clk = 1'b0;
    logic [W-1:0] l_d   = '0;
    logic [W-1:0] l_set = '0;
    logic [W-1:0] l_clr = '0;

    logic [W-1:0] qv [N];

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // u_dut: rising, set high, clear high
    sff_sampled_ff #(.WIDTH(W), .CLK_EDGE(EDGE_RISE), .SET_ACTIVE_HIGH(1'b1), .CLR_ACTIVE_HIGH(1'b1)) u_dut (
        .gclk(gclk), .rst_n(rst_n), .eclk_i(l_clk), .d_i(l_d),
        .set_i(l_set), .clr_i(l_clr), .q_o(qv[0]));
    // falling, set low, clear high
    sff_sampled_ff #(.WIDTH(W), .CLK_EDGE(EDGE_FALL), .SET_ACTIVE_HIGH(1'b0), .CLR_ACTIVE_HIGH(1'b1)) u_dut_b (
        .gclk(gclk), .rst_n(rst_n), .eclk_i(~l_clk), .d_i(l_d),
        .set_i(~l_set), .clr_i(l_clr), .q_o(qv[1]));
    // rising, set high, clear low
    sff_sampled_ff #(.WIDTH(W), .CLK_EDGE(EDGE_RISE), .SET_ACTIVE_HIGH(1'b1), .CLR_ACTIVE_HIGH(1'b0)) u_dut_c (
        .gclk(gclk), .rst_n(rst_n), .eclk_i(l_clk), .d_i(l_d),
        .set_i(l_set), .clr_i(~l_clr), .q_o(qv[2]));
    // falling, set low, clear low
    sff_sampled_ff #(.WIDTH(W), .CLK_EDGE(EDGE_FALL), .SET_ACTIVE_HIGH(1'b0), .CLR_ACTIVE_HIGH(1'b0)) u_dut_d (
        .gclk(gclk), .rst_n(rst_n), .eclk_i(~l_clk), .d_i(l_d),
        .set_i(~l_set), .clr_i(~l_clr), .q_o(qv[3]));

    // Apply one global cycle of stimulus, then settle before sampling.
    task automatic drive(input logic c, input logic [W-1:0] d,
                         input logic [W-1:0] s, input logic [W-1:0] r);
        @(negedge gclk);
        l_clk = c; l_d = d; l_set = s; l_clr = r;
        #2;
    endtask

    task automatic check(input string req, input logic [W-1:0] exp);
        for (int i = 0; i < N; i++) begin
            n_checks++;
            if (qv[i] !== exp) begin
                n_errors++;
                $display("FAIL %s inst%0d: actual=%h expected=%h", req, i, qv[i], exp);
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        drive(1'b0, '0, '0, '0);
        drive(1'b0, '0, '0, '0);
        check("R1 in reset", 8'h00);
        @(negedge gclk); rst_n = 1'b1; #2;
        check("R1 after release", 8'h00);
    endtask

    task automatic t_load_and_hold;
        drive(1'b0, 8'hA5, '0, '0);
        drive(1'b0, 8'h3C, '0, '0);
        drive(1'b1, 8'hFF, '0, '0);      // edge: value from the last global edge
        check("R2 load on active edge", 8'h3C);
        drive(1'b1, 8'h55, '0, '0);
        check("R3 hold at active level", 8'h3C);
        drive(1'b0, 8'h00, '0, '0);      // inactive transition
        check("R9 no load on inactive transition", 8'h3C);
        drive(1'b0, 8'h99, '0, '0);
        check("R3 hold at inactive level", 8'h3C);
    endtask

    task automatic t_set_alone;
        drive(1'b0, 8'h00, 8'h0F, '0);
        check("R4 set forces ones", 8'h3F);
        drive(1'b0, 8'h00, '0, '0);
        check("R7 set value retained", 8'h3F);
    endtask

    task automatic t_clear_alone;
        drive(1'b0, 8'hFF, '0, 8'h30);
        check("R5 clear forces zeros", 8'h0F);
        drive(1'b0, 8'hFF, '0, '0);
        check("R7 clear value retained", 8'h0F);
    endtask

    task automatic t_both;
        drive(1'b0, 8'h00, 8'hFF, 8'hF0);
        check("R5 clear wins over set", 8'h0F);
        drive(1'b0, 8'h00, '0, '0);
        check("R7 after both released", 8'h0F);
    endtask

    task automatic t_edge_under_override;
        drive(1'b0, 8'h00, 8'h80, 8'h01);
        check("R6 per-bit override", 8'h8E);
        drive(1'b1, 8'hFF, 8'h80, 8'h01);    // edge loads 00 in free bits
        check("R8 edge with override held", 8'h80);
        drive(1'b1, 8'hFF, '0, '0);
        check("R8 forced bits kept after release", 8'h80);
    endtask

    task automatic t_reload;
        drive(1'b0, 8'hAA, '0, '0);
        drive(1'b1, 8'h11, '0, '0);
        check("R2 second load", 8'hAA);
        drive(1'b1, 8'h22, '0, '0);
        drive(1'b1, 8'h33, '0, '0);
        check("R3 hold across data changes", 8'hAA);
    endtask

    initial begin
        t_reset();
        t_load_and_hold();
        t_set_alone();
        t_clear_alone();
        t_both();
        t_edge_under_override();
        t_reload();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule